// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block places incoming Ethernet frames into a packet memory that is organised as 256-byte pages. The pages between a programmable first page (inclusive) and limit page (exclusive) form a circular ring. The block drives a simple byte-wide RAM write port. Frame bytes arrive on a byte stream with start-of-frame and end-of-frame markers. At the end of a frame a good/bad indication and a receive-FIFO overrun indication are also supplied. MAC reception, CRC checking and address filtering take place upstream.

Every stored frame occupies a whole number of pages. Its data start at byte 4 of its first page. Once the frame has ended, a 4-byte header is written into bytes 0 to 3 of that first page. The block owns the write page pointer and advances it only after the header is complete. The host owns the read-side page register. The host sets that register to the page just before the next frame it will read. From this register the block decides whether the ring is empty and whether storing a byte would overwrite unread data. Bad frames and frames that would overwrite unread data are discarded by leaving the write page pointer where it was.

Top module: `rx_page_ring`

## Requirements
- R1: A pulse on `ring_init` sets `bnry_pg` to `cfg_start_pg` and `curr_pg` to `cfg_start_pg`+1, or to `cfg_start_pg` if that sum equals `cfg_stop_pg`. It also clears `ring_ovw` and returns the block to idle, with no RAM write in that cycle. After reset both page registers and `ring_ovw` are zero.
- R2: A beat with `rx_valid` and `rx_sof` in idle writes its byte to address {`curr_pg`, 8'd4}. Each further valid beat of the frame is written to the next byte address, one per cycle, in the same cycle as the beat.
- R3: When a data byte has been written at byte 255 of page `cfg_stop_pg`-1, the next byte goes to byte 0 of page `cfg_start_pg`.
- R4: After the beat carrying `rx_eof` with `rx_good`=1, the block writes the header in the next 4 cycles. The header goes to bytes 0,1,2,3 of the frame's first page, in this order: the status byte, the next-frame page, the byte count low byte and the byte count high byte. The byte count is the number of frame bytes plus 4.
- R5: The status byte has bit 0 set (frame intact), bit 3 equal to `rx_fifo_ovr` at the end beat, and all other bits zero.
- R6: In the cycle after the last header byte is written, `curr_pg` becomes the page after the page holding the frame's last byte, wrapped as in R3. `frame_done` pulses for that one cycle. `curr_pg` changes at no other time except on `ring_init`.
- R7: A frame that ends with `rx_good`=0 gets no header and leaves `curr_pg` unchanged. The next frame therefore starts on the same page.
- R8: A byte whose target page equals `bnry_pg` is not written. Its frame is discarded up to and including its `rx_eof` beat, `curr_pg` is unchanged, and `ring_ovw` is set and stays set until `ring_init`. The host must not set `bnry_pg` to a page of the frame being stored.
- R9: `ring_empty` is 1 exactly when `curr_pg` equals `bnry_pg`+1, where `bnry_pg`+1 wraps from `cfg_stop_pg` to `cfg_start_pg`.
- R10: `host_bnry_we` loads `host_bnry_wdata` into `bnry_pg` at the next clock edge, in every state. `ring_init` takes precedence.
- R11: In idle, valid beats without `rx_sof` are ignored. Valid beats that arrive during the 4 header cycles are also ignored. Neither causes a RAM write or a pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_start_pg | input | PAGE_W | First page of the ring |
| cfg_stop_pg | input | PAGE_W | Page just past the ring |
| ring_init | input | 1 | Initialise the pointers and clear the overwrite flag |
| host_bnry_we | input | 1 | Host write strobe for the read-side page |
| host_bnry_wdata | input | PAGE_W | New read-side page value |
| rx_valid | input | 1 | Stream byte valid |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Stream byte |
| rx_good | input | 1 | Frame good, sampled with rx_eof |
| rx_fifo_ovr | input | 1 | Receive FIFO overrun, sampled with rx_eof |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | PAGE_W+8 | RAM byte address {page, byte} |
| mem_wdata | output | 8 | RAM write data |
| curr_pg | output | PAGE_W | Write page pointer |
| bnry_pg | output | PAGE_W | Host read-side page |
| ring_empty | output | 1 | Ring holds no unread frame |
| ring_ovw | output | 1 | Sticky ring-overwrite flag |
| frame_done | output | 1 | One-cycle pulse when a frame is committed |

## Verification
The bench drives a frame whose data cross from the last ring page to the first. A design with a faulty wrap would write bytes beyond the limit page and would link the header to a page outside the ring. A frame whose next page comes out equal to the read-side page makes the ring full, and writing the read-side page so that it wraps to the limit page minus one makes the ring empty again. A wrong comparison there would report the ring empty when it is full, or full when it is empty. A bad frame followed by a good one checks that the write page is reused: a design that advanced anyway would leave a page with no header. A frame that runs into the read-side page, and beats sent during the header cycles, check that no unread byte is overwritten and that header bytes are not corrupted.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_HDR  = 2'd2,
        ST_DROP = 2'd3
    } ring_st_e;

    localparam int HDR_BYTES       = 4;
    localparam int CNT_W           = 16;
    localparam int STAT_INTACT_BIT = 0;
    localparam int STAT_OVR_BIT    = 3;
endpackage

// File: rtl/rx_ring_wrap.sv
module rx_ring_wrap #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [PAGE_W-1:0] first_pg,
    input  logic [PAGE_W-1:0] limit_pg,
    output logic [PAGE_W-1:0] next_pg
);
    logic [PAGE_W-1:0] plus1;

    always_comb begin
        plus1   = page + 1'b1;
        next_pg = (plus1 == limit_pg) ? first_pg : plus1;
    end
endmodule

// File: rtl/rx_ring_hdr_mux.sv
module rx_ring_hdr_mux #(
    parameter int PAGE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic [1:0]        sel,
    input  logic [7:0]        stat,
    input  logic [PAGE_W-1:0] link_pg,
    input  logic [CNT_W-1:0]  count,
    output logic [7:0]        hdr_byte
);
    always_comb begin
        unique case (sel)
            2'd0:    hdr_byte = stat;
            2'd1:    hdr_byte = 8'(link_pg);
            2'd2:    hdr_byte = count[7:0];
            default: hdr_byte = count[15:8];
        endcase
    end
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
    import rx_ring_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PAGE_W-1:0]   cfg_start_pg,
    input  logic [PAGE_W-1:0]   cfg_stop_pg,
    input  logic                ring_init,
    input  logic                host_bnry_we,
    input  logic [PAGE_W-1:0]   host_bnry_wdata,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic [7:0]          rx_data,
    input  logic                rx_good,
    input  logic                rx_fifo_ovr,
    output logic                mem_we,
    output logic [PAGE_W+7:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    output logic [PAGE_W-1:0]   curr_pg,
    output logic [PAGE_W-1:0]   bnry_pg,
    output logic                ring_empty,
    output logic                ring_ovw,
    output logic                frame_done
);
    localparam int MADDR_W = PAGE_W + 8;

    typedef struct packed {
        ring_st_e            st;
        logic [MADDR_W-1:0]  wp;
        logic [PAGE_W-1:0]   first;
        logic [CNT_W-1:0]    cnt;
        logic [7:0]          stat;
        logic [PAGE_W-1:0]   link;
        logic [1:0]          hidx;
        logic [PAGE_W-1:0]   curr;
        logic [PAGE_W-1:0]   bnry;
        logic                ovw;
        logic                done;
    } ring_regs_t;

    ring_regs_t q, d;

    logic [PAGE_W-1:0] init_curr;
    logic [PAGE_W-1:0] bnry_plus;
    logic [PAGE_W-1:0] last_pg;
    logic [PAGE_W-1:0] last_next;
    logic [7:0]        hdr_byte;
    logic [7:0]        stat_now;
    logic [PAGE_W-1:0] tgt_pg;

    assign last_pg = (q.st == ST_IDLE) ? q.curr : q.wp[MADDR_W-1:8];

    rx_ring_wrap #(.PAGE_W(PAGE_W)) u_wrap_init (
        .page(cfg_start_pg), .first_pg(cfg_start_pg), .limit_pg(cfg_stop_pg), .next_pg(init_curr)
    );
    rx_ring_wrap #(.PAGE_W(PAGE_W)) u_wrap_bnry (
        .page(q.bnry), .first_pg(cfg_start_pg), .limit_pg(cfg_stop_pg), .next_pg(bnry_plus)
    );
    rx_ring_wrap #(.PAGE_W(PAGE_W)) u_wrap_last (
        .page(last_pg), .first_pg(cfg_start_pg), .limit_pg(cfg_stop_pg), .next_pg(last_next)
    );
    rx_ring_hdr_mux #(.PAGE_W(PAGE_W), .CNT_W(CNT_W)) u_hdr_mux (
        .sel(q.hidx), .stat(q.stat), .link_pg(q.link), .count(q.cnt), .hdr_byte(hdr_byte)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.wp;
        mem_wdata = rx_data;
        stat_now  = '0;
        stat_now[STAT_INTACT_BIT] = 1'b1;
        stat_now[STAT_OVR_BIT]    = rx_fifo_ovr;
        tgt_pg    = (q.st == ST_IDLE) ? q.curr : q.wp[MADDR_W-1:8];

        if (ring_init) begin
            d.st   = ST_IDLE;
            d.curr = init_curr;
            d.bnry = cfg_start_pg;
            d.ovw  = 1'b0;
        end else begin
            if (host_bnry_we) begin
                d.bnry = host_bnry_wdata;
            end
            unique case (q.st)
                ST_IDLE, ST_DATA: begin
                    if (rx_valid && (rx_sof || q.st == ST_DATA)) begin
                        if (tgt_pg == q.bnry) begin
                            d.ovw = 1'b1;
                            d.st  = rx_eof ? ST_IDLE : ST_DROP;
                        end else begin
                            mem_we = 1'b1;
                            if (q.st == ST_IDLE) begin
                                mem_addr = {q.curr, 8'(HDR_BYTES)};
                                d.first  = q.curr;
                                d.cnt    = CNT_W'(HDR_BYTES + 1);
                                d.wp     = {q.curr, 8'(HDR_BYTES + 1)};
                            end else begin
                                d.cnt = q.cnt + 1'b1;
                                d.wp  = (q.wp[7:0] == 8'hFF) ? {last_next, 8'h00}
                                                             : q.wp + 1'b1;
                            end
                            if (!rx_eof) begin
                                d.st = ST_DATA;
                            end else if (rx_good) begin
                                d.st   = ST_HDR;
                                d.hidx = 2'd0;
                                d.link = last_next;
                                d.stat = stat_now;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end
                    end
                end
                ST_HDR: begin
                    mem_we    = 1'b1;
                    mem_addr  = {q.first, 8'(q.hidx)};
                    mem_wdata = hdr_byte;
                    d.hidx    = q.hidx + 1'b1;
                    if (q.hidx == 2'd3) begin
                        d.st   = ST_IDLE;
                        d.curr = q.link;
                        d.done = 1'b1;
                    end
                end
                default: begin
                    if (rx_valid && rx_eof) begin
                        d.st = ST_IDLE;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign curr_pg    = q.curr;
    assign bnry_pg    = q.bnry;
    assign ring_empty = (q.curr == bnry_plus);
    assign ring_ovw   = q.ovw;
    assign frame_done = q.done;
endmodule

// File: rtl/rx_page_ring_chk.sv
module rx_page_ring_chk #(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PAGE_W-1:0] cfg_start_pg,
    input logic [PAGE_W-1:0] cfg_stop_pg,
    input logic              ring_init,
    input logic              host_bnry_we,
    input logic [PAGE_W-1:0] host_bnry_wdata,
    input logic              mem_we,
    input logic [PAGE_W+7:0] mem_addr,
    input logic [PAGE_W-1:0] curr_pg,
    input logic [PAGE_W-1:0] bnry_pg,
    input logic              ring_ovw,
    input logic              frame_done
);
    logic [PAGE_W-1:0] exp_init_curr;
    logic [PAGE_W-1:0] start_p1;

    always_comb begin
        start_p1      = cfg_start_pg + 1'b1;
        exp_init_curr = (start_p1 == cfg_stop_pg) ? cfg_start_pg : start_p1;
    end

    assert_init_ptrs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ring_init |=> (curr_pg == $past(exp_init_curr)) && (bnry_pg == $past(cfg_start_pg)) && !ring_ovw);

    assert_no_unread_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PAGE_W+7:8] != bnry_pg));

    assert_ovw_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_ovw && !ring_init) |=> ring_ovw);

    assert_curr_moves_on_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(curr_pg) |-> (frame_done || $past(ring_init)));

    assert_bnry_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_bnry_we && !ring_init) |=> (bnry_pg == $past(host_bnry_wdata)));
endmodule

bind rx_page_ring rx_page_ring_chk #(.PAGE_W(PAGE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg),
    .ring_init(ring_init), .host_bnry_we(host_bnry_we), .host_bnry_wdata(host_bnry_wdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .curr_pg(curr_pg), .bnry_pg(bnry_pg),
    .ring_ovw(ring_ovw), .frame_done(frame_done)
);

// File: tb/test_rx_page_ring.sv
module test_rx_page_ring;
    localparam int CLK_PERIOD = 10;
    localparam int PAGE_W     = 8;
    localparam int START_PG   = 2;
    localparam int STOP_PG    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ring_init = 1'b0, host_bnry_we = 1'b0;
    logic [PAGE_W-1:0] host_bnry_wdata = '0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_good = 1'b0, rx_fifo_ovr = 1'b0;
    logic [7:0] rx_data = '0;
    logic mem_we, ring_empty, ring_ovw, frame_done;
    logic [PAGE_W+7:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [PAGE_W-1:0] curr_pg, bnry_pg;

    int n_chk = 0;
    int n_fail = 0;
    byte unsigned mem [int];

    // reference model state
    int m_st, m_wp, m_first, m_cnt, m_stat, m_link, m_hidx, m_curr, m_bnry, m_ovw, m_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_page_ring #(.PAGE_W(PAGE_W)) i_rx_page_ring (
        .clk(clk), .rst_n(rst_n),
        .cfg_start_pg(PAGE_W'(START_PG)), .cfg_stop_pg(PAGE_W'(STOP_PG)),
        .ring_init(ring_init), .host_bnry_we(host_bnry_we), .host_bnry_wdata(host_bnry_wdata),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
        .rx_good(rx_good), .rx_fifo_ovr(rx_fifo_ovr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .curr_pg(curr_pg), .bnry_pg(bnry_pg), .ring_empty(ring_empty),
        .ring_ovw(ring_ovw), .frame_done(frame_done)
    );

    function automatic int inc_pg(int p);
        return (p + 1 == STOP_PG) ? START_PG : p + 1;
    endfunction

    function automatic int dat(int id, int i);
        return (id * 37 + i * 3) & 255;
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int rd(int a);
        return mem.exists(a) ? int'(mem[a]) : -1;
    endfunction

    // cycle-by-cycle comparison and model update, one unit before each rising edge
    always @(negedge clk) begin
        #(CLK_PERIOD/2 - 1);
        if (!rst_n) begin
            m_st = 0; m_wp = 0; m_first = 0; m_cnt = 0; m_stat = 0; m_link = 0;
            m_hidx = 0; m_curr = 0; m_bnry = 0; m_ovw = 0; m_done = 0;
        end else begin
            int e_we, e_addr, e_data, tgt;
            int n_st, n_wp, n_first, n_cnt, n_stat, n_link, n_hidx, n_curr, n_bnry, n_ovw, n_done;
            e_we = 0; e_addr = 0; e_data = 0;
            n_st = m_st; n_wp = m_wp; n_first = m_first; n_cnt = m_cnt; n_stat = m_stat;
            n_link = m_link; n_hidx = m_hidx; n_curr = m_curr; n_bnry = m_bnry; n_ovw = m_ovw; n_done = 0;
            // registered outputs
            cmp("R6", "curr_pg", int'(curr_pg), m_curr);
            cmp("R10", "bnry_pg", int'(bnry_pg), m_bnry);
            cmp("R8", "ring_ovw", int'(ring_ovw), m_ovw);
            cmp("R6", "frame_done", int'(frame_done), m_done);
            cmp("R9", "ring_empty", int'(ring_empty), (m_curr == inc_pg(m_bnry)) ? 1 : 0);
            if (ring_init) begin
                n_st = 0; n_curr = inc_pg(START_PG); n_bnry = START_PG; n_ovw = 0;
            end else begin
                if (host_bnry_we) n_bnry = int'(host_bnry_wdata);
                if ((m_st == 0 && rx_valid && rx_sof) || (m_st == 1 && rx_valid)) begin
                    tgt = (m_st == 0) ? m_curr : (m_wp >> 8);
                    if (tgt == m_bnry) begin
                        n_ovw = 1;
                        n_st = rx_eof ? 0 : 3;
                    end else begin
                        e_we = 1; e_data = int'(rx_data);
                        if (m_st == 0) begin
                            e_addr = m_curr * 256 + 4; n_first = m_curr; n_cnt = 5; n_wp = m_curr * 256 + 5;
                        end else begin
                            e_addr = m_wp; n_cnt = m_cnt + 1;
                            n_wp = ((m_wp & 255) == 255) ? inc_pg(m_wp >> 8) * 256 : m_wp + 1;
                        end
                        if (!rx_eof) n_st = 1;
                        else if (rx_good) begin
                            n_st = 2; n_hidx = 0; n_link = inc_pg(tgt);
                            n_stat = 1 | (rx_fifo_ovr ? 8 : 0);
                        end else n_st = 0;
                    end
                end else if (m_st == 2) begin
                    e_we = 1; e_addr = m_first * 256 + m_hidx;
                    case (m_hidx)
                        0: e_data = m_stat;
                        1: e_data = m_link;
                        2: e_data = m_cnt & 255;
                        default: e_data = (m_cnt >> 8) & 255;
                    endcase
                    n_hidx = m_hidx + 1;
                    if (m_hidx == 3) begin n_st = 0; n_curr = m_link; n_done = 1; end
                end else if (m_st == 3 && rx_valid && rx_eof) begin
                    n_st = 0;
                end
            end
            cmp("R2", "mem_we", int'(mem_we), e_we);
            if (e_we == 1) begin
                cmp("R2", "mem_addr", int'(mem_addr), e_addr);
                cmp("R4", "mem_wdata", int'(mem_wdata), e_data);
            end
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            m_st = n_st; m_wp = n_wp; m_first = n_first; m_cnt = n_cnt; m_stat = n_stat;
            m_link = n_link; m_hidx = n_hidx; m_curr = n_curr; m_bnry = n_bnry; m_ovw = n_ovw; m_done = n_done;
        end
    end

    task automatic idle_cycles(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_frame(int id, int len, bit good, bit ovr, int tail);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = 8'(dat(id, i)); rx_good = good; rx_fifo_ovr = ovr;
        end
        for (int t = 0; t < tail; t++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b0; rx_data = 8'hEE;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0; rx_fifo_ovr = 1'b0;
        idle_cycles(7);
    endtask

    task automatic write_bnry(int v);
        @(negedge clk);
        host_bnry_we = 1'b1; host_bnry_wdata = PAGE_W'(v);
        @(negedge clk);
        host_bnry_we = 1'b0;
        idle_cycles(1);
    endtask

    task automatic pulse_init();
        @(negedge clk); ring_init = 1'b1;
        @(negedge clk); ring_init = 1'b0;
        idle_cycles(1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int saved;
        idle_cycles(3);
        cmp("R1", "reset curr_pg", int'(curr_pg), 0);
        cmp("R1", "reset bnry_pg", int'(bnry_pg), 0);
        cmp("R1", "reset ring_ovw", int'(ring_ovw), 0);
        rst_n = 1'b1;
        idle_cycles(2);

        // R1 / R9: initialisation gives an empty ring
        pulse_init();
        cmp("R1", "init curr_pg", int'(curr_pg), 3);
        cmp("R1", "init bnry_pg", int'(bnry_pg), 2);
        cmp("R9", "init ring_empty", int'(ring_empty), 1);

        // R11: beats without start in idle are ignored
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'h5A;
        end
        @(negedge clk); rx_valid = 1'b0;
        idle_cycles(2);
        cmp("R11", "stray beat wrote 0x304", rd(32'h304), -1);
        cmp("R11", "stray beat curr_pg", int'(curr_pg), 3);

        // R2 / R4 / R6: a short good frame
        send_frame(1, 60, 1'b1, 1'b0, 0);
        cmp("R5", "hdr status", rd(32'h300), 8'h01);
        cmp("R4", "hdr link", rd(32'h301), 4);
        cmp("R4", "hdr count lo", rd(32'h302), 64);
        cmp("R4", "hdr count hi", rd(32'h303), 0);
        cmp("R2", "first data byte", rd(32'h304), dat(1, 0));
        cmp("R2", "last data byte", rd(32'h33F), dat(1, 59));
        cmp("R6", "curr after frame 1", int'(curr_pg), 4);
        cmp("R9", "not empty", int'(ring_empty), 0);

        // R7: bad frame leaves no header and no pointer move
        send_frame(2, 100, 1'b0, 1'b0, 0);
        cmp("R7", "bad frame curr_pg", int'(curr_pg), 4);
        cmp("R7", "bad frame header absent", rd(32'h400), -1);

        // R5 / R7: next frame reuses the page, carries the overrun flag, link wraps
        send_frame(3, 300, 1'b1, 1'b1, 0);
        cmp("R5", "hdr status with overrun", rd(32'h400), 8'h09);
        cmp("R7", "reused page data", rd(32'h404), dat(3, 0));
        cmp("R4", "hdr link wrapped", rd(32'h401), 2);
        cmp("R4", "hdr count lo 304", rd(32'h402), 8'h30);
        cmp("R4", "hdr count hi 304", rd(32'h403), 8'h01);
        cmp("R6", "curr wrapped to start", int'(curr_pg), 2);
        cmp("R9", "full ring not empty", int'(ring_empty), 0);

        // R10 / R9: host moves boundary to the wrap value
        write_bnry(5);
        cmp("R10", "bnry written", int'(bnry_pg), 5);
        cmp("R9", "empty via wrapped boundary", int'(ring_empty), 1);

        send_frame(4, 600, 1'b1, 1'b0, 0);
        cmp("R4", "frame 4 link", rd(32'h201), 5);
        cmp("R4", "frame 4 count lo", rd(32'h202), 8'h5C);
        cmp("R6", "curr after frame 4", int'(curr_pg), 5);
        write_bnry(4);

        // R3: frame data cross the limit page
        send_frame(5, 400, 1'b1, 1'b0, 0);
        cmp("R3", "byte before wrap", rd(32'h5FF), dat(5, 251));
        cmp("R3", "byte after wrap", rd(32'h200), dat(5, 252));
        cmp("R3", "frame 5 link", rd(32'h501), 3);
        cmp("R4", "frame 5 count lo", rd(32'h502), 8'h94);
        cmp("R4", "frame 5 count hi", rd(32'h503), 8'h01);
        cmp("R6", "curr after frame 5", int'(curr_pg), 3);

        // R8: frame runs into the unread page
        saved = rd(32'h400);
        send_frame(6, 500, 1'b1, 1'b0, 0);
        cmp("R8", "ring_ovw set", int'(ring_ovw), 1);
        cmp("R8", "curr unchanged", int'(curr_pg), 3);
        cmp("R8", "unread page untouched", rd(32'h400), saved);

        // R11: single-byte frame with beats during the header cycles
        send_frame(7, 1, 1'b1, 1'b0, 2);
        cmp("R11", "hdr link kept", rd(32'h301), 4);
        cmp("R11", "hdr count kept", rd(32'h302), 5);
        cmp("R11", "single byte", rd(32'h304), dat(7, 0));
        cmp("R11", "no write past single byte", rd(32'h305), dat(6, 1));
        cmp("R6", "curr after single byte", int'(curr_pg), 4);
        cmp("R8", "ring_ovw still set", int'(ring_ovw), 1);

        // R1: re-initialise clears the flag
        pulse_init();
        cmp("R1", "reinit ring_ovw", int'(ring_ovw), 0);
        cmp("R1", "reinit curr_pg", int'(curr_pg), 3);
        cmp("R1", "reinit bnry_pg", int'(bnry_pg), 2);
        idle_cycles(3);
        finish_run();
    end
endmodule